// File: doc/BRIEF.md
# Conflict-Free FFT Schedule Address Generator

This block produces the operand order for an in-place radix-2 FFT of D = 2^N points whose data sits in exactly G = 2^T single-ported memory banks. Each cycle it can present one group of G datapoint indices, together with the bank that holds each index. It walks the stages 0 to N-1 and, in each stage, the D/G groups of that stage. The order is chosen so that no group of G consecutive accesses in a stage touches any bank twice. This holds for the aligned groups and also for the windows that straddle two aligned groups. A butterfly datapath with an overlapped read/write pipeline can therefore fetch and store without stalls.

Three steps produce the indices. First, a base index is built in which the T bits that vary inside a group sit side by side. That field moves up one position per stage and, near the top of the index, rotates in place. Second, a parity map folds the index bits into a T-bit bank number. Third, each varying bit is replaced by the bank bit that depends on it. After this step the lanes of every aligned group in a stage list their banks in the same fixed order. A start pulse launches a run, a valid/ready pair paces the groups, and a one-cycle done pulse closes the run.

Top module: `cfree_fft_agen`

## Requirements
- R1: After reset grp_valid and done are 0. No group appears without a start. A start is taken only when the block is idle, meaning no run is active and no group is waiting. A run then presents exactly N*D/G groups: stages 0..N-1 in ascending order, each with D/G groups.
- R2: Within one stage, every index 0..D-1 appears exactly once.
- R3: In stage s, lanes 2m and 2m+1 of every group carry indices whose XOR is exactly 2^s.
- R4: The bank of every lane is the parity fold of its index: bank bit c is the XOR of all index bits at positions q with q mod T = c.
- R5: In stage s, lane k of every group uses bank k rotated left by (s mod T) within T bits. With G=4 this gives 0,1,2,3 in even stages and 0,2,1,3 in odd stages. With D=256 and G=8, the stride-16 stage (s=4) gives 0,2,4,6,1,3,5,7.
- R6: Any window of G consecutive accesses within one stage uses G distinct banks. With G=4, the half-shifted windows read banks 2,3,0,1 in even stages and 1,3,0,2 in odd stages.
- R7: The index is formed from stage s, group g and lane k in two steps. First, a T-bit field starts at position p = min(s, N-T). Bit j of k sits at position p + ((j + s - p) mod T). The bits of g fill the other positions from low to high. Second, every field bit at position q is replaced by bank bit (q mod T) of that first index. For D=8 and G=4, stage 2 emits 0,4,2,6 and then 5,1,7,3.
- R8: While grp_valid is 1 and grp_ready is 0, grp_valid, grp_stage, grp_index and grp_bank hold their values. A group is never dropped or repeated.
- R9: done is a single-cycle pulse, once per run. It is high in the cycle after the last group of stage N-1 is accepted.
- R10: A start asserted while a run is in progress has no effect on the group stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| grp_ready | input | 1 | Consumer accepts the presented group |
| grp_valid | output | 1 | A group is presented |
| grp_stage | output | clog2(N) | Stage number of the presented group |
| grp_index | output | G*N | Lane k index in bits [k*N +: N] |
| grp_bank | output | G*T | Lane k bank in bits [k*T +: T] |
| done | output | 1 | One-cycle pulse after the final group is taken |

## Verification
The bound checker checks several properties on every cycle. Each lane's bank must equal the parity fold of its index. The G banks of a presented group must all differ. Lane 1 must sit on the bank that the stage's rotation predicts. A stalled group must stay frozen, and done must follow an accepted group. Some properties span a whole stage or a whole run, and only the bench scenarios show them. These are the exact index sequence, each index appearing once per stage, the 2^s pairing stride, distinct banks in windows that cross group boundaries, the total group count, and the fact that a start during a run is ignored. The bench checks them under continuous and randomly throttled ready for three size and group combinations.

// File: rtl/cfs_pkg.sv
// Shared limits and helpers for the conflict-free schedule generator.
// Assumes group sizes up to 32, so a toggle field fits in five bits.
package cfs_pkg;
    localparam int MIN_POINTS = 8;
    localparam int MAX_POINTS = 8192;
    localparam int MIN_GROUP  = 2;
    localparam int MAX_GROUP  = 32;
    localparam int FIELD_MAX  = 5;

    // Rotate the low w bits of v left by amt; upper bits come back as zero.
    function automatic logic [FIELD_MAX-1:0] rotl_field(input logic [FIELD_MAX-1:0] v,
                                                        input int amt, input int w);
        logic [FIELD_MAX-1:0] r;
        r = '0;
        for (int i = 0; i < FIELD_MAX; i++) begin
            if (i < w && v[i]) r = r | (FIELD_MAX'(1) << ((i + amt) % w));
        end
        return r;
    endfunction
endpackage

// File: rtl/cfs_bank_map.sv
// Parity bank map: bank bit c is the XOR of index bits c, c+T, c+2T, ...
// Pure combinational; T independent XOR trees of fan-in ceil(N/T).
module cfs_bank_map #(
    parameter int N = 8,
    parameter int T = 3
) (
    input  logic [N-1:0] idx,
    output logic [T-1:0] bank
);
    for (genvar c = 0; c < T; c++) begin : g_tree
        logic acc;
        // Fold every T-th index bit starting at c.
        always_comb begin
            acc = 1'b0;
            for (int j = c; j < N; j += T) acc = acc ^ idx[j];
        end
        assign bank[c] = acc;
    end
endmodule

// File: rtl/cfs_lane.sv
// One lane of a group: builds the base index with an adjacent toggle field,
// maps it to a bank and rewrites the field so the lane's bank is fixed per stage.
// Assumes stage < N and LANE < 2^T; purely combinational.
module cfs_lane #(
    parameter int N    = 8,
    parameter int T    = 3,
    parameter int LANE = 0,
    localparam int SW  = $clog2(N),
    localparam int GW  = N - T,
    localparam int GCW = (GW > 0) ? GW : 1
) (
    input  logic [SW-1:0]  stage,
    input  logic [GCW-1:0] group,
    output logic [N-1:0]   index,
    output logic [T-1:0]   bank
);
    logic [N-1:0] base;
    logic [T-1:0] base_bank;
    int           fpos;

    // Place the toggle field (rotated once it reaches the top) and the group bits.
    always_comb begin : p_base
        int s;
        int rot;
        logic [cfs_pkg::FIELD_MAX-1:0] fld;
        logic [31:0] g32;
        logic [31:0] lowm;
        logic [31:0] b32;
        s = int'(stage);
        if (s > GW) begin
            fpos = GW;
            rot  = s - GW;
        end else begin
            fpos = s;
            rot  = 0;
        end
        fld  = cfs_pkg::rotl_field(cfs_pkg::FIELD_MAX'(LANE), rot, T);
        g32  = 32'(group);
        lowm = (32'd1 << fpos) - 32'd1;
        b32  = (g32 & lowm) | (32'(fld) << fpos) | ((g32 >> fpos) << (fpos + T));
        base = b32[N-1:0];
    end

    cfs_bank_map #(.N(N), .T(T)) u_map (
        .idx  (base),
        .bank (base_bank)
    );

    // Swap each field bit for its bank bit; the old field bits become the bank.
    always_comb begin : p_reorder
        bank = '0;
        for (int j = 0; j < N; j++) begin
            if (j >= fpos && j < fpos + T) begin
                index[j]   = base_bank[j % T];
                bank[j % T] = base[j];
            end else begin
                index[j] = base[j];
            end
        end
    end
endmodule

// File: rtl/cfs_seq.sv
// Stage/group walker: holds the next group to present and advances on each load.
// Assumes adv is only asserted while run is high.
module cfs_seq #(
    parameter int N   = 8,
    parameter int T   = 3,
    localparam int SW  = $clog2(N),
    localparam int GW  = N - T,
    localparam int GCW = (GW > 0) ? GW : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           idle,
    input  logic           adv,
    output logic           run,
    output logic [SW-1:0]  stage,
    output logic [GCW-1:0] group,
    output logic           last
);
    localparam logic [GCW-1:0] GMAX = GCW'((1 << GW) - 1);
    localparam logic [SW-1:0]  SMAX = SW'(N - 1);

    // Final group of the final stage.
    assign last = (stage == SMAX) && (group == GMAX);

    // Launch on an idle start, then step group-major through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            stage <= '0;
            group <= '0;
        end else if (!run) begin
            if (start && idle) begin
                run   <= 1'b1;
                stage <= '0;
                group <= '0;
            end
        end else if (adv) begin
            if (last) begin
                run <= 1'b0;
            end else if (group == GMAX) begin
                group <= '0;
                stage <= stage + 1'b1;
            end else begin
                group <= group + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfree_fft_agen.sv
// Conflict-free FFT schedule address generator, top level.
// Presents one registered group of G index/bank pairs per accepted cycle for
// an in-place radix-2 FFT of D points. Assumes D and G are powers of two,
// 8 <= D <= 8192, 2 <= G <= 32, G <= D.
module cfree_fft_agen #(
    parameter int D = 256,
    parameter int G = 8,
    localparam int N  = $clog2(D),
    localparam int T  = $clog2(G),
    localparam int SW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            grp_ready,
    output logic            grp_valid,
    output logic [SW-1:0]   grp_stage,
    output logic [G*N-1:0]  grp_index,
    output logic [G*T-1:0]  grp_bank,
    output logic            done
);
    localparam int GW  = N - T;
    localparam int GCW = (GW > 0) ? GW : 1;

    logic           run;
    logic           seq_last;
    logic           load;
    logic [SW-1:0]  cur_stage;
    logic [GCW-1:0] cur_group;
    logic [G*N-1:0] nxt_index;
    logic [G*T-1:0] nxt_bank;
    logic           vld_q;
    logic           last_q;
    logic           done_q;
    logic [SW-1:0]  stage_q;
    logic [G*N-1:0] index_q;
    logic [G*T-1:0] bank_q;

    // Fill the output register when it is empty or being drained.
    assign load = run && (!vld_q || grp_ready);

    cfs_seq #(.N(N), .T(T)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .idle  (!vld_q),
        .adv   (load),
        .run   (run),
        .stage (cur_stage),
        .group (cur_group),
        .last  (seq_last)
    );

    for (genvar k = 0; k < G; k++) begin : g_lane
        cfs_lane #(.N(N), .T(T), .LANE(k)) u_lane (
            .stage (cur_stage),
            .group (cur_group),
            .index (nxt_index[k*N +: N]),
            .bank  (nxt_bank[k*T +: T])
        );
    end

    // Output register with valid/ready hold and the end-of-run pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            stage_q <= '0;
            index_q <= '0;
            bank_q  <= '0;
        end else begin
            done_q <= vld_q && grp_ready && last_q;
            if (load) begin
                vld_q   <= 1'b1;
                last_q  <= seq_last;
                stage_q <= cur_stage;
                index_q <= nxt_index;
                bank_q  <= nxt_bank;
            end else if (grp_ready) begin
                vld_q <= 1'b0;
            end
        end
    end

    assign grp_valid = vld_q;
    assign grp_stage = stage_q;
    assign grp_index = index_q;
    assign grp_bank  = bank_q;
    assign done      = done_q;
endmodule

// File: rtl/cfree_fft_agen_chk.sv
// Property checker for cfree_fft_agen, attached by bind below.
// Observes ports only.
module cfree_fft_agen_chk #(
    parameter int D = 256,
    parameter int G = 8,
    localparam int N  = $clog2(D),
    localparam int T  = $clog2(G),
    localparam int SW = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           grp_ready,
    input logic           grp_valid,
    input logic [SW-1:0]  grp_stage,
    input logic [G*N-1:0] grp_index,
    input logic [G*T-1:0] grp_bank,
    input logic           done
);
    logic [G-1:0] used;
    logic [T-1:0] lane1_exp;

    // Parameter legality, checked once at start.
    initial begin
        assert_params_legal: assert ((1 << N) == D && (1 << T) == G && D >= cfs_pkg::MIN_POINTS
            && D <= cfs_pkg::MAX_POINTS && G >= cfs_pkg::MIN_GROUP && G <= cfs_pkg::MAX_GROUP
            && G <= D) else $error("cfree_fft_agen: illegal D=%0d G=%0d", D, G);
    end

    // Set of banks touched by the presented group.
    always_comb begin
        used = '0;
        for (int k = 0; k < G; k++) used[grp_bank[k*T +: T]] = 1'b1;
    end

    // Lane 1 bank predicted by the per-stage rotation.
    always_comb lane1_exp = T'(1) << (int'(grp_stage) % T);

    for (genvar k = 0; k < G; k++) begin : g_lane
        logic [N-1:0] ix;
        logic [T-1:0] fold;
        assign ix = grp_index[k*N +: N];
        // Parity fold of this lane's index.
        always_comb begin
            fold = '0;
            for (int j = 0; j < N; j++) fold[j % T] = fold[j % T] ^ ix[j];
        end
        assert_bank_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            grp_valid |-> grp_bank[k*T +: T] == fold);
    end

    assert_banks_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> $countones(used) == G);

    assert_lane1_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> grp_bank[T +: T] == lane1_exp);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid && !grp_ready |=> grp_valid && $stable(grp_index) && $stable(grp_bank)
                                    && $stable(grp_stage));

    assert_done_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(grp_valid && grp_ready));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind cfree_fft_agen cfree_fft_agen_chk #(.D(D), .G(G)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .grp_ready (grp_ready),
    .grp_valid (grp_valid),
    .grp_stage (grp_stage),
    .grp_index (grp_index),
    .grp_bank  (grp_bank),
    .done      (done)
);

// File: tb/cfree_fft_agen_runner.sv
// Drives and checks one generator instance for a given D and G.
module cfree_fft_agen_runner #(
    parameter int D    = 8,
    parameter int G    = 4,
    parameter int SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic finished,
    output int   n_chk,
    output int   n_bad
);
    localparam int N      = $clog2(D);
    localparam int T      = $clog2(G);
    localparam int SW     = $clog2(N);
    localparam int NGRP   = D / G;
    localparam int TOTAL  = N * NGRP;

    logic           start;
    logic           grp_ready;
    logic           grp_valid;
    logic [SW-1:0]  grp_stage;
    logic [G*N-1:0] grp_index;
    logic [G*T-1:0] grp_bank;
    logic           done;

    cfree_fft_agen #(.D(D), .G(G)) u_cfree_fft_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .grp_ready (grp_ready),
        .grp_valid (grp_valid),
        .grp_stage (grp_stage),
        .grp_index (grp_index),
        .grp_bank  (grp_bank),
        .done      (done)
    );

    bit seen [D];
    int sbank [D];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (D=%0d G=%0d): got %0d expected %0d", req, D, G, act, expv);
        end
    endtask

    function automatic int fold(input int ix);
        int b = 0;
        for (int q = 0; q < N; q++) if ((ix >> q) & 1) b = b ^ (1 << (q % T));
        return b;
    endfunction

    function automatic int rotl(input int k, input int a);
        return ((k << a) | (k >> (T - a))) & (G - 1);
    endfunction

    // Expected index from the placement and rewrite rule of R7.
    function automatic int exp_index(input int s, input int g, input int k);
        int p = (s <= N - T) ? s : N - T;
        int base = 0, used = 0, gi = 0, b, res;
        for (int j = 0; j < T; j++) begin
            int pos = p + ((j + s - p) % T);
            base |= ((k >> j) & 1) << pos;
            used |= 1 << pos;
        end
        for (int q = 0; q < N; q++) begin
            if (((used >> q) & 1) == 0) begin
                base |= ((g >> gi) & 1) << q;
                gi++;
            end
        end
        b = fold(base);
        res = base & ~used;
        for (int q = 0; q < N; q++)
            if ((used >> q) & 1) res |= ((b >> (q % T)) & 1) << q;
        return res;
    endfunction

    int exp_s, exp_g, ngrp, ndone, spos;
    bit prev_last, hold_pend;
    logic [G*N-1:0] h_index;
    logic [G*T-1:0] h_bank;
    logic [SW-1:0]  h_stage;

    task automatic stage_end();
        int missing = 0;
        for (int i = 0; i < D; i++) if (!seen[i]) missing++;
        chk(missing == 0, "R2", missing, 0);
        for (int w = 0; w + G <= D; w++) begin
            int m = 0;
            for (int i = 0; i < G; i++) m |= 1 << sbank[w + i];
            chk($countones(m) == G, "R6", $countones(m), G);
        end
        if (G == 4 && D == 8) begin
            int ev[4] = '{2, 3, 0, 1};
            int od[4] = '{1, 3, 0, 2};
            for (int i = 0; i < 4; i++)
                chk(sbank[2 + i] == ((exp_s % 2 == 0) ? ev[i] : od[i]), "R6",
                    sbank[2 + i], (exp_s % 2 == 0) ? ev[i] : od[i]);
        end
        for (int i = 0; i < D; i++) seen[i] = 0;
        spos = 0;
    endtask

    task automatic take_group();
        int ix[G];
        int bk[G];
        int r7_list[8] = '{0, 4, 2, 6, 5, 1, 7, 3};
        int g8_list[8] = '{0, 2, 4, 6, 1, 3, 5, 7};
        chk(int'(grp_stage) == exp_s, "R1", int'(grp_stage), exp_s);
        for (int k = 0; k < G; k++) begin
            ix[k] = int'(grp_index[k*N +: N]);
            bk[k] = int'(grp_bank[k*T +: T]);
        end
        for (int k = 0; k < G; k++) begin
            int e = exp_index(exp_s, exp_g, k);
            chk(ix[k] == e, "R7", ix[k], e);
            chk(bk[k] == fold(ix[k]), "R4", bk[k], fold(ix[k]));
            chk(bk[k] == rotl(k, exp_s % T), "R5", bk[k], rotl(k, exp_s % T));
            if (D == 8 && G == 4 && exp_s == 2)
                chk(ix[k] == r7_list[exp_g*4 + k], "R7", ix[k], r7_list[exp_g*4 + k]);
            if (D == 256 && G == 8 && exp_s == 4)
                chk(bk[k] == g8_list[k], "R5", bk[k], g8_list[k]);
            chk(!seen[ix[k]], "R2", ix[k], -1);
            seen[ix[k]] = 1;
            sbank[spos] = bk[k];
            spos++;
        end
        for (int m = 0; m < G; m += 2)
            chk((ix[m] ^ ix[m+1]) == (1 << exp_s), "R3", ix[m] ^ ix[m+1], 1 << exp_s);
        ngrp++;
        if (exp_g == NGRP - 1) begin
            stage_end();
            exp_g = 0;
            exp_s++;
        end else begin
            exp_g++;
        end
    endtask

    // mode 0: ready always high, start held high during the run.
    // mode 1: random ready, a single start pulse in mid-run.
    task automatic do_run(input int mode);
        bit cur_last;
        exp_s = 0; exp_g = 0; ngrp = 0; ndone = 0; spos = 0;
        prev_last = 0; hold_pend = 0;
        for (int i = 0; i < D; i++) seen[i] = 0;
        start = 1'b1;
        @(negedge clk);
        if (mode == 1) start = 1'b0;
        for (int cyc = 0; cyc < 4 * TOTAL + 40 && ndone == 0; cyc++) begin
            @(negedge clk);
            if (hold_pend)
                chk(grp_valid && grp_index == h_index && grp_bank == h_bank
                    && grp_stage == h_stage, "R8", int'(grp_valid), 1);
            if (done) begin
                chk(prev_last, "R9", int'(prev_last), 1);
                ndone++;
                start = 1'b0;
            end
            if (ndone == 0) begin
                grp_ready = (mode == 0) ? 1'b1 : (($urandom % 4) != 0);
                if (mode == 1) start = (ngrp == TOTAL / 2);
            end else begin
                grp_ready = 1'b1;
            end
            hold_pend = grp_valid && !grp_ready;
            h_index = grp_index; h_bank = grp_bank; h_stage = grp_stage;
            cur_last = 0;
            if (grp_valid && grp_ready && ndone == 0) begin
                cur_last = (exp_s == N - 1) && (exp_g == NGRP - 1);
                take_group();
            end
            prev_last = cur_last;
        end
        start = 1'b0;
        chk(ndone == 1, "R9", ndone, 1);
        chk(ngrp == TOTAL, "R10", ngrp, TOTAL);
        chk(ngrp == TOTAL, "R1", ngrp, TOTAL);
        repeat (3) begin
            @(negedge clk);
            chk(!grp_valid && !done, "R9", int'(grp_valid) + int'(done), 0);
        end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(SEED);
        finished = 1'b0;
        n_chk = 0;
        n_bad = 0;
        start = 1'b0;
        grp_ready = 1'b0;
        @(negedge clk);
        chk(!grp_valid && !done, "R1", int'(grp_valid) + int'(done), 0);
        wait (rst_n == 1'b1);
        grp_ready = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!grp_valid, "R1", int'(grp_valid), 0);
        end
        do_run(0);
        do_run(1);
        finished = 1'b1;
    end
endmodule

// File: tb/cfree_fft_agen_bench.sv
// Bench top: three generator configurations run side by side.
module cfree_fft_agen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fin_a, fin_b, fin_c;
    int   chk_a, chk_b, chk_c, bad_a, bad_b, bad_c;
    bit   reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfree_fft_agen_runner #(.D(256), .G(8), .SEED(11)) u_run_a (
        .clk(clk), .rst_n(rst_n), .finished(fin_a), .n_chk(chk_a), .n_bad(bad_a));
    cfree_fft_agen_runner #(.D(8), .G(4), .SEED(23)) u_run_b (
        .clk(clk), .rst_n(rst_n), .finished(fin_b), .n_chk(chk_b), .n_bad(bad_b));
    cfree_fft_agen_runner #(.D(32), .G(2), .SEED(37)) u_run_c (
        .clk(clk), .rst_n(rst_n), .finished(fin_c), .n_chk(chk_c), .n_bad(bad_c));

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        wait (fin_a === 1'b1 && fin_b === 1'b1 && fin_c === 1'b1);
        @(negedge clk);
        if (!reported) begin
            reported = 1;
            $display("  == %0d vectors applied, %0d miscompares ==",
                     chk_a + chk_b + chk_c, bad_a + bad_b + bad_c);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!reported) begin
            reported = 1;
            $display("FAIL watchdog: got %0d finished runners expected 3",
                     int'(fin_a === 1'b1) + int'(fin_b === 1'b1) + int'(fin_c === 1'b1));
            $display("  == %0d vectors applied, %0d miscompares ==",
                     chk_a + chk_b + chk_c + 1, bad_a + bad_b + bad_c + 1);
            $finish;
        end
    end
endmodule